// File: doc/BRIEF.md
# Asynchronous Character Transmitter with Break Control

This block serializes 8-bit characters onto a single idle-high serial line. Characters are written through a valid/ready port into an eight-entry queue inside the block. A shifter takes them one at a time and sends each as a low start bit, eight data bits with the least significant bit first, and one or two high stop bits. The bit rate comes from a one-cycle bit-time enable, `bit_en`, which runs in the system clock domain. The serial output changes only on cycles where that enable is high.

A break input takes control of the line at the next bit-time enable and drives it low. The character being sent at that moment is dropped and is never sent again. Characters still waiting in the queue are kept, and no new character starts while break is held. When break is released, the line goes high for one bit time, and the queued characters then go out as usual.

A flush pulse empties the queue and returns the shifter to idle. The flush is separate from break: it does not lift an active break.

Top module: `async_tx_break`

## Requirements
- R1: While reset is active and directly after it, `txd` is 1, `busy` is 0 and `wr_ready` is 1.
- R2: Each character is sent as one 0 start bit, then data bits 0 through 7 in that order, then high stop bits. `txd` changes only in the cycle after a cycle where `bit_en` is 1.
- R3: `two_stop` is sampled when a character is taken from the queue. A value of 0 gives one stop bit and a value of 1 gives two. A queued character's start bit follows the last stop bit with no idle bit between them.
- R4: The queue holds 8 characters and sends them in write order. `wr_ready` is 0 while the queue is full, and a write offered while `wr_ready` is 0 is dropped.
- R5: When `brk` is 1 in a `bit_en` cycle, `txd` is 0 from the next cycle onward. Before that cycle, `txd` is not changed.
- R6: A character that break interrupts is discarded and is not sent again.
- R7: While break holds the line, no character starts, queued characters are kept, and `busy` is 0.
- R8: After `brk` returns to 0, the next bit time drives `txd` to 1. The queued characters then start at the following bit time.
- R9: A `flush` pulse empties the queue and returns the shifter to idle. A write in the same cycle is dropped. In the next cycle `wr_ready` is 1 and `busy` is 0. Without break, `txd` is 1 from the next bit time onward.
- R10: `flush` does not clear break. `txd` stays 0 until `brk` goes to 0.
- R11: `busy` is 1 whenever a character is being shifted, or whenever the queue is not empty and `brk` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | One-cycle bit-time enable |
| wr_valid | input | 1 | Write request |
| wr_data | input | 8 | Character to queue |
| wr_ready | output | 1 | Queue can accept a character |
| two_stop | input | 1 | 0 selects one stop bit, 1 selects two |
| brk | input | 1 | Break: hold the line low |
| flush | input | 1 | Transmit reset pulse |
| txd | output | 1 | Serial output, idle high |
| busy | output | 1 | Transmitter has work |

## Verification
The assertions expect `bit_en` to be a pulse of one cycle. They also expect `brk` and `flush` to be ordinary synchronous levels that are 0 during reset, so the properties on next-cycle values follow from a single registered step. The stimulus drives every input on the falling clock edge. It spaces bit-time enables four cycles apart and changes `brk`, `flush` and writes only between enables, so each checked cycle sees one clear cause. The sweep sends all 256 character values in full queue batches under both stop settings.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_DATA = 2'd1,
        TX_STOP = 2'd2,
        TX_HOLD = 2'd3
    } tx_state_e;

endpackage

// File: rtl/async_tx_fifo.sv
module async_tx_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP      = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [AW-1:0]               rd;
        logic [AW-1:0]               wr;
        logic [CW-1:0]               cnt;
    } fifo_t;

    fifo_t q, d;
    logic  do_push, do_pop;

    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == CAP);
    assign head  = q.mem[q.rd];

    always_comb begin
        d       = q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (flush) begin
            d.rd  = '0;
            d.wr  = '0;
            d.cnt = '0;
        end else begin
            if (do_push) begin
                d.mem[q.wr] = push_data;
                d.wr        = (q.wr == LAST_IDX) ? '0 : q.wr + 1'b1;
            end
            if (do_pop) begin
                d.rd = (q.rd == LAST_IDX) ? '0 : q.rd + 1'b1;
            end
            if (do_push && !do_pop) begin
                d.cnt = q.cnt + 1'b1;
            end else if (do_pop && !do_push) begin
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/async_tx_shifter.sv
module async_tx_shifter
    import async_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              brk,
    input  logic              flush,
    input  logic              two_stop,
    input  logic              avail,
    input  logic [DATA_W-1:0] din,
    output logic              pop,
    output logic              txd,
    output logic              active
);
    localparam int CNTW = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNTW-1:0] LAST_BIT = CNTW'(DATA_W - 1);

    typedef struct packed {
        tx_state_e         state;
        logic [DATA_W-1:0] shreg;
        logic [CNTW-1:0]   cnt;
        logic              stop2;
        logic              txd;
    } shift_t;

    shift_t q, d;

    assign txd    = q.txd;
    assign active = (q.state == TX_DATA) || (q.state == TX_STOP);

    always_comb begin
        d   = q;
        pop = 1'b0;
        if (bit_en && brk) begin
            // Break wins over everything: the line goes low and the character is dropped.
            d.state = TX_HOLD;
            d.txd   = 1'b0;
        end else if (flush) begin
            // A flush keeps a pending break recovery so the idle gap is still sent.
            d.state = (q.state == TX_HOLD) ? TX_HOLD : TX_IDLE;
        end else if (bit_en) begin
            unique case (q.state)
                TX_IDLE: begin
                    if (avail) begin
                        pop     = 1'b1;
                        d.txd   = 1'b0;
                        d.shreg = din;
                        d.cnt   = '0;
                        d.stop2 = two_stop;
                        d.state = TX_DATA;
                    end else begin
                        d.txd = 1'b1;
                    end
                end
                TX_DATA: begin
                    d.txd   = q.shreg[0];
                    d.shreg = q.shreg >> 1;
                    if (q.cnt == LAST_BIT) begin
                        d.cnt   = '0;
                        d.state = TX_STOP;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                TX_STOP: begin
                    d.txd = 1'b1;
                    if (q.stop2 && (q.cnt == '0)) begin
                        d.cnt = q.cnt + 1'b1;
                    end else begin
                        d.cnt   = '0;
                        d.state = TX_IDLE;
                    end
                end
                TX_HOLD: begin
                    d.txd   = 1'b1;
                    d.state = TX_IDLE;
                end
                default: begin
                    d.state = TX_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= TX_IDLE;
            q.txd   <= 1'b1;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/async_tx_break.sv
module async_tx_break #(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              two_stop,
    input  logic              brk,
    input  logic              flush,
    output logic              txd,
    output logic              busy
);
    logic              q_empty;
    logic              q_full;
    logic              q_pop;
    logic [DATA_W-1:0] q_head;
    logic              sh_active;

    async_tx_fifo #(
        .WIDTH(DATA_W),
        .DEPTH(FIFO_DEPTH)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .push     (wr_valid),
        .push_data(wr_data),
        .pop      (q_pop),
        .head     (q_head),
        .empty    (q_empty),
        .full     (q_full)
    );

    async_tx_shifter #(
        .DATA_W(DATA_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .brk     (brk),
        .flush   (flush),
        .two_stop(two_stop),
        .avail   (!q_empty),
        .din     (q_head),
        .pop     (q_pop),
        .txd     (txd),
        .active  (sh_active)
    );

    assign wr_ready = !q_full;
    assign busy     = sh_active || (!q_empty && !brk);

endmodule

// File: rtl/async_tx_break_checker.sv
module async_tx_break_checker (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic brk,
    input logic flush,
    input logic txd,
    input logic busy,
    input logic wr_ready
);

    assert_txd_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(txd));

    assert_break_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && brk) |=> !txd);

    assert_break_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (brk && $past(bit_en && brk)) |-> !busy);

    assert_flush_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (wr_ready && !busy));

    assert_flush_keeps_break_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && brk && !txd) |=> !txd);

endmodule

bind async_tx_break async_tx_break_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_en  (bit_en),
    .brk     (brk),
    .flush   (flush),
    .txd     (txd),
    .busy    (busy),
    .wr_ready(wr_ready)
);

// File: tb/async_tx_break_test.sv
module async_tx_break_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_ready;
    logic       two_stop = 1'b0;
    logic       brk = 1'b0;
    logic       flush = 1'b0;
    logic       txd;
    logic       busy;

    int  n_vec  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    async_tx_break uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .wr_valid(wr_valid),
        .wr_data (wr_data),
        .wr_ready(wr_ready),
        .two_stop(two_stop),
        .brk     (brk),
        .flush   (flush),
        .txd     (txd),
        .busy    (busy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One bit time: enable for one cycle, sample after the update, confirm no change mid-bit.
    task automatic bit_time(output logic s);
        @(negedge clk) bit_en = 1'b1;
        @(negedge clk) bit_en = 1'b0;
        s = txd;
        repeat (2) @(negedge clk);
        chk(txd == s, "R2 mid-bit stable", int'(txd), int'(s));
    endtask

    task automatic expect_bit(input logic e, input string tag);
        logic s;
        bit_time(s);
        chk(s === e, tag, int'(s), int'(e));
    endtask

    task automatic push(input logic [7:0] v, input logic exp_ready);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = v;
        chk(wr_ready === exp_ready, "R4 wr_ready", int'(wr_ready), int'(exp_ready));
        @(negedge clk) wr_valid = 1'b0;
    endtask

    task automatic frame(input logic [7:0] v, input int nstop);
        expect_bit(1'b0, "R2 start bit");
        for (int i = 0; i < 8; i++) expect_bit(v[i], "R2 data bit");
        for (int k = 0; k < nstop; k++) expect_bit(1'b1, "R3 stop bit");
    endtask

    task automatic pulse_flush();
        @(negedge clk) flush = 1'b1;
        @(negedge clk) flush = 1'b0;
        chk(wr_ready === 1'b1, "R9 ready after flush", int'(wr_ready), 1);
        chk(busy === 1'b0, "R9 idle after flush", int'(busy), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        logic s;
        repeat (3) @(negedge clk);
        chk(txd === 1'b1, "R1 txd in reset", int'(txd), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd === 1'b1, "R1 txd idle", int'(txd), 1);
        chk(busy === 1'b0, "R1 busy", int'(busy), 0);
        chk(wr_ready === 1'b1, "R1 wr_ready", int'(wr_ready), 1);
        expect_bit(1'b1, "R1 idle line");

        // Sweep every character value in full-queue batches under both stop settings.
        for (int sm = 0; sm < 2; sm++) begin
            two_stop = sm[0];
            for (int b = 0; b < 32; b++) begin
                for (int i = 0; i < 8; i++) push(8'(b * 8 + i), 1'b1);
                push(8'hA5, 1'b0);  // R4: full queue rejects the ninth
                chk(busy === 1'b1, "R11 busy with queued data", int'(busy), 1);
                for (int i = 0; i < 8; i++) frame(8'(b * 8 + i), sm + 1);
                expect_bit(1'b1, "R4 nothing after eight");
                chk(busy === 1'b0, "R11 busy after drain", int'(busy), 0);
            end
        end

        // Break in the middle of a character.
        two_stop = 1'b0;
        push(8'h3C, 1'b1);
        push(8'h81, 1'b1);
        push(8'h5A, 1'b1);
        expect_bit(1'b0, "R2 start before break");
        expect_bit(1'b0, "R2 bit0");
        expect_bit(1'b0, "R2 bit1");
        expect_bit(1'b1, "R2 bit2");
        @(negedge clk) brk = 1'b1;
        repeat (2) @(negedge clk);
        chk(txd === 1'b1, "R5 no change before tick", int'(txd), 1);
        for (int i = 0; i < 4; i++) begin
            expect_bit(1'b0, "R5 break low");
            chk(busy === 1'b0, "R7 not busy in break", int'(busy), 0);
            chk(wr_ready === 1'b1, "R7 queue kept", int'(wr_ready), 1);
        end
        @(negedge clk) brk = 1'b0;
        @(negedge clk);
        chk(busy === 1'b1, "R11 queued after release", int'(busy), 1);
        expect_bit(1'b1, "R8 idle gap");
        frame(8'h81, 1);   // R6: 3C is not resent
        frame(8'h5A, 1);
        expect_bit(1'b1, "R6 no resend");
        chk(busy === 1'b0, "R6 drained", int'(busy), 0);

        // Flush during a character, no break.
        push(8'hF0, 1'b1);
        push(8'h0F, 1'b1);
        expect_bit(1'b0, "R2 start before flush");
        expect_bit(1'b0, "R2 bit0 before flush");
        pulse_flush();
        expect_bit(1'b1, "R9 line high after flush");
        expect_bit(1'b1, "R9 queue emptied");
        chk(busy === 1'b0, "R9 still idle", int'(busy), 0);

        // Flush while break is held.
        push(8'h77, 1'b1);
        expect_bit(1'b0, "R2 start before break flush");
        @(negedge clk) brk = 1'b1;
        expect_bit(1'b0, "R5 break low");
        pulse_flush();
        expect_bit(1'b0, "R10 break survives flush");
        expect_bit(1'b0, "R10 break still low");
        @(negedge clk) brk = 1'b0;
        expect_bit(1'b1, "R8 gap after release");
        expect_bit(1'b1, "R9 nothing queued");
        chk(busy === 1'b0, "R9 idle at end", int'(busy), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule